// File: doc/BRIEF.md
# Streaming 1-D Segment Dilation/Erosion Filter

The block applies a grey-scale dilation (running maximum) or erosion (running minimum) by a flat 1-D segment to a line of pixels that arrives one sample at a time. For output position x the segment covers input positions x-L through x+R, where L is the left extent and R the right extent. The segment is clipped at both ends of the line. Every input is read once and every result is written once, in position order. No line buffer is kept.

The filter keeps a short double-ended queue of candidate extrema, each tagged with a position stamp. When a new sample arrives, entries that the sample dominates are dropped from the back and the sample is appended. When the window slides, the entry at the front is retired once it falls out of reach.

The line length, both extents and the operation are programmed between lines. A controller with four states sequences the work:
- read a sample;
- trim the back of the queue and append;
- emit results from the front;
- close the line.

A sample costs three cycles, plus one cycle for each queue entry it drops.

Top module: `morph_line_filter`

## Requirements
- R1: After reset, in_ready_o is 1 and out_valid_o is 0. The active setting is then: line length MAX_LEN, both extents 0, dilation. A line streamed with no configuration load therefore comes out unchanged.
- R2: With cfg_erode_i = 0, result x equals the maximum of the inputs at positions max(0,x-L) through min(N-1,x+R).
- R3: With cfg_erode_i = 1, result x equals the minimum of the same clipped range.
- R4: Each line yields exactly N results. out_last_o is 1 only on the result for position N-1. out_valid_o is 0 in the cycle after that result is taken.
- R5: Results leave in position order, one per input position. in_ready_o and out_valid_o are never 1 in the same cycle.
- R6: While out_valid_o is 1 and out_ready_i is 0, out_valid_o, out_data_o and out_last_o hold their values into the next cycle.
- R7: A pulse on cfg_load_i is accepted only when no line is in progress, or in the cycle that follows the last result of a line. A pulse that arrives after the first pixel of a line has been accepted has no effect, on that line or on any later line.
- R8: Clipping is correct in every case, including a line of length 1, L = R = 0 (identity), and extents longer than the line.
- R9: Queue occupancy never exceeds L+R+1. Results stay correct for a long monotonic run followed by a large step against it, which drops many entries at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load request for the line setting |
| cfg_len_i | input | $clog2(MAX_LEN+1) | Line length N (1..MAX_LEN) |
| cfg_left_i | input | $clog2(MAX_LEFT+1) | Left extent L |
| cfg_right_i | input | $clog2(MAX_RIGHT+1) | Right extent R |
| cfg_erode_i | input | 1 | 1 selects erosion, 0 selects dilation |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Input sample accepted when both valid and ready are 1 |
| in_data_i | input | DW | Input sample |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream accepts the result |
| out_data_o | output | DW | Result value |
| out_last_o | output | 1 | Marks the result for the final position of the line |

## Verification
The assertions rely on three conditions at the inputs:
- the programmed length is at least 1;
- the programmed extents lie within MAX_LEFT and MAX_RIGHT;
- configuration is pulsed only between lines, so the stored setting does not move while results are outstanding.

The stimulus respects all three. Each setting is drawn within the legal ranges, and lines run one after another, with a setting load issued only after the marked final result has been taken. The only exception is the deliberate mid-line pulse, and the block must discard it. Random input gaps and random downstream stalls are mixed in on each line, so the hold and exclusion properties are exercised under back-pressure.

// File: rtl/morph_pkg.sv
package morph_pkg;
  typedef enum logic [1:0] {
    ST_RD  = 2'd0,
    ST_DEQ = 2'd1,
    ST_OUT = 2'd2,
    ST_EOL = 2'd3
  } fsm_e;
endpackage

// File: rtl/morph_deque.sv
module morph_deque #(
  parameter int DW    = 8,
  parameter int SW    = 5,
  parameter int DEPTH = 31
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] val_i,
  input  logic [SW-1:0] stp_i,
  input  logic          pop_back_i,
  input  logic          pop_front_i,
  output logic [DW-1:0] front_val_o,
  output logic [SW-1:0] front_stp_o,
  output logic [DW-1:0] back_val_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNW = $clog2(DEPTH+1);

  logic [DW-1:0] val_m [DEPTH];
  logic [SW-1:0] stp_m [DEPTH];
  logic [PW-1:0] head_q, tail_q, back_idx;
  logic [CNW-1:0] cnt_q;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  assign back_idx = (tail_q == '0) ? PW'(DEPTH-1) : tail_q - PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i)          tail_q <= wrap_inc(tail_q);
      else if (pop_back_i) tail_q <= back_idx;
      if (pop_front_i)     head_q <= wrap_inc(head_q);
      cnt_q <= cnt_q + CNW'(push_i) - CNW'(pop_back_i) - CNW'(pop_front_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      val_m[tail_q] <= val_i;
      stp_m[tail_q] <= stp_i;
    end
  end

  assign front_val_o = val_m[head_q];
  assign front_stp_o = stp_m[head_q];
  assign back_val_o  = val_m[back_idx];
  assign cnt_o       = cnt_q;
endmodule

// File: rtl/morph_mod_ctr.sv
module morph_mod_ctr #(
  parameter int VW = 5,
  parameter int MW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [VW-1:0] load_val_i,
  input  logic          inc_i,
  input  logic [MW-1:0] mod_i,
  output logic [VW-1:0] val_o
);
  logic [VW-1:0] val_q;
  logic [MW-1:0] plus1;

  assign plus1 = MW'(val_q) + MW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= (plus1 == mod_i) ? '0 : VW'(plus1);
  end

  assign val_o = val_q;
endmodule

// File: rtl/morph_line_filter.sv
module morph_line_filter
  import morph_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MAX_LEN   = 64,
  parameter int MAX_LEFT  = 15,
  parameter int MAX_RIGHT = 15
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cfg_load_i,
  input  logic [$clog2(MAX_LEN+1)-1:0]     cfg_len_i,
  input  logic [$clog2(MAX_LEFT+1)-1:0]    cfg_left_i,
  input  logic [$clog2(MAX_RIGHT+1)-1:0]   cfg_right_i,
  input  logic                             cfg_erode_i,
  input  logic                             in_valid_i,
  output logic                             in_ready_o,
  input  logic [DW-1:0]                    in_data_i,
  output logic                             out_valid_o,
  input  logic                             out_ready_i,
  output logic [DW-1:0]                    out_data_o,
  output logic                             out_last_o
);
  localparam int LW  = $clog2(MAX_LEN+1);
  localparam int LFW = $clog2(MAX_LEFT+1);
  localparam int RTW = $clog2(MAX_RIGHT+1);
  localparam int QD  = MAX_LEFT + MAX_RIGHT + 1;
  localparam int SW  = (QD > 1) ? $clog2(QD) : 1;
  localparam int MW  = $clog2(QD+1);
  localparam int CNW = $clog2(QD+1);
  localparam int CW  = LW + 1;

  fsm_e state_q, state_d;
  logic [LW-1:0]  len_q, len_n;
  logic [LFW-1:0] left_q, left_n;
  logic [RTW-1:0] right_q, right_n;
  logic           erode_q, erode_n;
  logic           busy_q, load_ok, cfg_take;
  logic [LW-1:0]  rd_cnt_q, wp_q;
  logic [DW-1:0]  smp_q;

  logic           q_push, q_pop_b, q_pop_f, emit, drop_back, wp_last, stp_load;
  logic [DW-1:0]  front_val, back_val;
  logic [SW-1:0]  front_stp, rd_stp, exp_stp, exp_init;
  logic [CNW-1:0] q_cnt;
  logic [MW-1:0]  mod_val;

  // result at wp is ready once the right edge of its window has been read
  function automatic logic res_ready(input logic [LW-1:0] rd, input logic [LW-1:0] wp,
                                     input logic [LW-1:0] len, input logic [RTW-1:0] rgt);
    return (rd == len) || (CW'(rd) >= CW'(wp) + CW'(rgt) + CW'(1));
  endfunction

  assign load_ok  = (state_q == ST_EOL) || !busy_q;
  assign cfg_take = cfg_load_i && load_ok;
  assign len_n    = cfg_take ? cfg_len_i   : len_q;
  assign left_n   = cfg_take ? cfg_left_i  : left_q;
  assign right_n  = cfg_take ? cfg_right_i : right_q;
  assign erode_n  = cfg_take ? cfg_erode_i : erode_q;

  // expiry stamp starts at (-L) mod (L+R+1)
  assign exp_init = (left_n == '0) ? '0 : SW'(right_n) + SW'(1);
  assign mod_val  = MW'(left_q) + MW'(right_q) + MW'(1);
  assign stp_load = (state_q == ST_EOL) || cfg_take;

  assign drop_back = (q_cnt != '0) &&
                     (erode_q ? (back_val >= smp_q) : (back_val <= smp_q));
  assign wp_last   = (wp_q == len_q - LW'(1));

  always_comb begin
    state_d = state_q;
    q_push  = 1'b0;
    q_pop_b = 1'b0;
    emit    = 1'b0;
    unique case (state_q)
      ST_RD:  if (in_valid_i) state_d = ST_DEQ;
      ST_DEQ: begin
        if (drop_back) q_pop_b = 1'b1;
        else begin
          q_push  = 1'b1;
          state_d = res_ready(rd_cnt_q + LW'(1), wp_q, len_q, right_q) ? ST_OUT : ST_RD;
        end
      end
      ST_OUT: begin
        if (out_ready_i) begin
          emit = 1'b1;
          if (wp_last) state_d = ST_EOL;
          else state_d = res_ready(rd_cnt_q, wp_q + LW'(1), len_q, right_q) ? ST_OUT : ST_RD;
        end
      end
      ST_EOL: state_d = ST_RD;
      default: state_d = ST_RD;
    endcase
  end

  // front leaves the window after this result; value stays valid this cycle
  assign q_pop_f = emit && (front_stp == exp_stp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RD;
      len_q    <= LW'(MAX_LEN);
      left_q   <= '0;
      right_q  <= '0;
      erode_q  <= 1'b0;
      busy_q   <= 1'b0;
      rd_cnt_q <= '0;
      wp_q     <= '0;
      smp_q    <= '0;
    end else begin
      state_q <= state_d;
      len_q   <= len_n;
      left_q  <= left_n;
      right_q <= right_n;
      erode_q <= erode_n;
      if (state_q == ST_RD && in_valid_i) begin
        smp_q  <= in_data_i;
        busy_q <= 1'b1;
      end
      if (q_push) rd_cnt_q <= rd_cnt_q + LW'(1);
      if (emit)   wp_q     <= wp_q + LW'(1);
      if (state_q == ST_EOL) begin
        busy_q   <= 1'b0;
        rd_cnt_q <= '0;
        wp_q     <= '0;
      end
    end
  end

  morph_deque #(.DW(DW), .SW(SW), .DEPTH(QD)) u_deque (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (state_q == ST_EOL),
    .push_i      (q_push),
    .val_i       (smp_q),
    .stp_i       (rd_stp),
    .pop_back_i  (q_pop_b),
    .pop_front_i (q_pop_f),
    .front_val_o (front_val),
    .front_stp_o (front_stp),
    .back_val_o  (back_val),
    .cnt_o       (q_cnt)
  );

  morph_mod_ctr #(.VW(SW), .MW(MW)) u_rd_stp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (stp_load),
    .load_val_i ('0),
    .inc_i      (q_push),
    .mod_i      (mod_val),
    .val_o      (rd_stp)
  );

  morph_mod_ctr #(.VW(SW), .MW(MW)) u_exp_stp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (stp_load),
    .load_val_i (exp_init),
    .inc_i      (emit),
    .mod_i      (mod_val),
    .val_o      (exp_stp)
  );

  assign in_ready_o  = (state_q == ST_RD);
  assign out_valid_o = (state_q == ST_OUT);
  assign out_data_o  = front_val;
  assign out_last_o  = out_valid_o && wp_last;
endmodule

// File: rtl/morph_line_filter_chk.sv
module morph_line_filter_chk #(
  parameter int DW  = 8,
  parameter int LW  = 7,
  parameter int LFW = 4,
  parameter int RTW = 4,
  parameter int CNW = 5
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           in_ready_o,
  input logic           out_valid_o,
  input logic           out_ready_i,
  input logic [DW-1:0]  out_data_o,
  input logic           out_last_o,
  input logic [CNW-1:0] q_cnt_i,
  input logic [LFW-1:0] left_i,
  input logic [RTW-1:0] right_i,
  input logic [LW-1:0]  len_i
);
  logic [LW-1:0] res_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_cnt <= '0;
    else if (out_valid_o && out_ready_i) res_cnt <= out_last_o ? '0 : res_cnt + LW'(1);
  end

  p_last_pos_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_last_o |-> res_cnt == len_i - LW'(1));
  p_last_seen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && res_cnt == len_i - LW'(1) |-> out_last_o);
  p_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> !out_valid_o);
  p_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));
  p_cfg_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_cnt != '0 |=> $stable(len_i) && $stable(left_i) && $stable(right_i));
  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(q_cnt_i) <= int'(left_i) + int'(right_i) + 1);
endmodule

bind morph_line_filter morph_line_filter_chk #(
  .DW(DW), .LW(LW), .LFW(LFW), .RTW(RTW), .CNW(CNW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o),
  .q_cnt_i     (q_cnt),
  .left_i      (left_q),
  .right_i     (right_q),
  .len_i       (len_q)
);

// File: tb/morph_line_filter_tb_top.sv
module morph_line_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 8;
  localparam int MAXN = 64;
  localparam int MAXL = 15;
  localparam int MAXR = 15;
  localparam int LW   = $clog2(MAXN+1);
  localparam int LFW  = $clog2(MAXL+1);
  localparam int RTW  = $clog2(MAXR+1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_load_i = 1'b0;
  logic [LW-1:0] cfg_len_i = '0;
  logic [LFW-1:0] cfg_left_i = '0;
  logic [RTW-1:0] cfg_right_i = '0;
  logic cfg_erode_i = 1'b0;
  logic in_valid_i = 1'b0;
  logic in_ready_o;
  logic [DW-1:0] in_data_i = '0;
  logic out_valid_o;
  logic out_ready_i = 1'b0;
  logic [DW-1:0] out_data_o;
  logic out_last_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  morph_line_filter #(.DW(DW), .MAX_LEN(MAXN), .MAX_LEFT(MAXL), .MAX_RIGHT(MAXR)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_load_i(cfg_load_i), .cfg_len_i(cfg_len_i), .cfg_left_i(cfg_left_i),
    .cfg_right_i(cfg_right_i), .cfg_erode_i(cfg_erode_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_data_o(out_data_o), .out_last_o(out_last_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] pix [MAXN];
  int cur_len, cur_l, cur_r;
  bit cur_er;
  int gap_max = 0;
  int rdy_pct = 100;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int golden(input int x);
    int lo, hi, acc;
    lo = (x - cur_l < 0) ? 0 : x - cur_l;
    hi = (x + cur_r > cur_len - 1) ? cur_len - 1 : x + cur_r;
    acc = int'(pix[lo]);
    for (int i = lo + 1; i <= hi; i++) begin
      if (cur_er) acc = (int'(pix[i]) < acc) ? int'(pix[i]) : acc;
      else        acc = (int'(pix[i]) > acc) ? int'(pix[i]) : acc;
    end
    return acc;
  endfunction

  // 0 random, 1 few levels, 2 falling run then jump, 3 rising run then drop
  task automatic fill(input int mode);
    for (int i = 0; i < MAXN; i++) begin
      case (mode)
        1: pix[i] = DW'($urandom % 4);
        2: pix[i] = (i == cur_len - 1) ? 8'd255 : DW'(250 - 3 * i);
        3: pix[i] = (i == cur_len - 1) ? 8'd0 : DW'(5 + 3 * i);
        default: pix[i] = DW'($urandom);
      endcase
    end
  endtask

  task automatic configure(input int len, input int l, input int r, input bit er);
    cur_len = len; cur_l = l; cur_r = r; cur_er = er;
    @(negedge clk);
    cfg_load_i = 1'b1; cfg_len_i = LW'(len); cfg_left_i = LFW'(l);
    cfg_right_i = RTW'(r); cfg_erode_i = er;
    @(posedge clk); #1;
    cfg_load_i = 1'b0;
  endtask

  task automatic drive_line(input bit mid_cfg);
    for (int i = 0; i < cur_len; i++) begin
      if (gap_max > 0) repeat ($urandom_range(gap_max, 0)) @(negedge clk);
      @(negedge clk);
      in_valid_i = 1'b1;
      in_data_i  = pix[i];
      while (!in_ready_o) @(negedge clk);
      @(posedge clk); #1;
      in_valid_i = 1'b0;
      if (mid_cfg && i == 0) begin
        @(negedge clk);
        cfg_load_i = 1'b1; cfg_len_i = LW'(7); cfg_left_i = '0;
        cfg_right_i = '0; cfg_erode_i = ~cur_er;
        @(posedge clk); #1;
        cfg_load_i = 1'b0;
      end
    end
  endtask

  task automatic collect_line(input string dtag);
    bit held;
    logic [DW-1:0] hv, got;
    logic gl;
    for (int k = 0; k < cur_len; k++) begin
      held = 1'b0;
      forever begin
        @(negedge clk);
        chk(!(in_ready_o && out_valid_o), "R5", int'(in_ready_o && out_valid_o), 0);
        if (held) chk(out_valid_o && out_data_o == hv, "R6", int'(out_data_o), int'(hv));
        out_ready_i = (($urandom % 100) < rdy_pct);
        if (out_valid_o && out_ready_i) begin
          got = out_data_o; gl = out_last_o;
          break;
        end
        held = out_valid_o; hv = out_data_o;
      end
      chk(int'(got) == golden(k), dtag, int'(got), golden(k));
      chk(gl == (k == cur_len - 1), "R4", int'(gl), int'(k == cur_len - 1));
      @(posedge clk); #1;
      out_ready_i = 1'b0;
    end
    repeat (2) begin
      @(negedge clk);
      chk(!out_valid_o, "R4", int'(out_valid_o), 0);
    end
  endtask

  task automatic run_line(input string dtag, input bit mid_cfg);
    fork
      drive_line(mid_cfg);
      collect_line(dtag);
    join
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready_o == 1'b1, "R1", int'(in_ready_o), 1);
    chk(out_valid_o == 1'b0, "R1", int'(out_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(in_ready_o == 1'b1, "R1", int'(in_ready_o), 1);
    chk(out_valid_o == 1'b0, "R1", int'(out_valid_o), 0);

    // default setting: full-length identity dilation
    cur_len = MAXN; cur_l = 0; cur_r = 0; cur_er = 1'b0;
    fill(0);
    run_line("R1", 1'b0);

    configure(1, 3, 2, 1'b0); fill(0); run_line("R8", 1'b0);
    configure(1, 0, 0, 1'b1); fill(0); run_line("R8", 1'b0);
    configure(10, 0, 0, 1'b1); fill(0); run_line("R8", 1'b0);
    configure(5, 15, 15, 1'b0); fill(0); run_line("R8", 1'b0);
    configure(5, 15, 15, 1'b1); fill(0); run_line("R8", 1'b0);
    configure(40, 6, 3, 1'b0); fill(2); run_line("R9", 1'b0);
    configure(40, 3, 6, 1'b1); fill(3); run_line("R9", 1'b0);
    gap_max = 2; rdy_pct = 40;
    configure(20, 2, 2, 1'b0); fill(1); run_line("R2", 1'b0);
    configure(20, 2, 2, 1'b1); fill(1); run_line("R3", 1'b0);
    configure(30, 4, 1, 1'b1); fill(0); run_line("R7", 1'b1);
    fill(0); run_line("R7", 1'b0);

    for (int n = 0; n < 30; n++) begin
      gap_max = $urandom % 4;
      rdy_pct = 30 + ($urandom % 71);
      configure(1 + ($urandom % MAXN), $urandom % (MAXL + 1), $urandom % (MAXR + 1), 1'($urandom % 2));
      fill($urandom % 2);
      run_line(cur_er ? "R3" : "R2", 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule